// File: doc/BRIEF.md
# Single-source machine-mode interrupt controller

This block sits beside a small RISC-V style core and decides whether a single external interrupt request may be taken. It watches four inputs: the request, the global interrupt enable, a strobe that marks an exception being taken, and a strobe that marks a return-from-trap instruction. The block keeps two independent busy flags, one for an active exception handler and one for an active interrupt handler. A new interrupt is granted only when both flags are clear and no exception is arriving in the same cycle.

The flags unwind in nesting order. When an exception is taken inside an interrupt handler, the first return clears only the exception flag. The second return clears the interrupt flag and raises the interrupt-return output. The cause output is a fixed code with the interrupt bit set. The core loads it into its cause register whenever a grant is taken.

Top module: `irq_ctrl`

## Requirements
- R1: `grant_o` is high in the same cycle, combinationally, when `req_i` and `gie_i` are high, `trap_i` is low and neither busy flag is set.
- R2: While `gie_i` is low, `grant_o` stays low whatever the other inputs do.
- R3: After a grant, no further request is granted until a return clears the interrupt flag.
- R4: A request is not granted in the cycle where `trap_i` is high. It is also not granted in the cycle that follows.
- R5: A return while only the interrupt flag is set drives `ret_o` high in that same cycle. A request in the next cycle is granted.
- R6: A return while only the exception flag is set leaves `ret_o` low. A request in the next cycle is granted.
- R7: When an exception is taken during an interrupt, the first return leaves `ret_o` low and a request after it is not granted. The second return drives `ret_o` high, and a request after it is granted.
- R8: `cause_o` is constantly 32'h8000_0010: bit 31 set, with cause code 16 in the low bits.
- R9: An active-low asynchronous reset `rst_ni` clears both flags. While it is low, `grant_o` and `ret_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trap_i | input | 1 | Exception taken this cycle |
| req_i | input | 1 | External interrupt request |
| mret_i | input | 1 | Return-from-trap this cycle |
| gie_i | input | 1 | Global interrupt enable |
| grant_o | output | 1 | Interrupt taken this cycle |
| ret_o | output | 1 | Return ends the interrupt handler |
| cause_o | output | 32 | Fixed interrupt cause code |

## Verification
`grant_o` and `ret_o` are combinational, so each result is due in the same cycle as the inputs that cause it. The busy flags change only on the following rising edge, so they affect the outputs one cycle later. The bench applies each input vector at a falling edge and queues the expected outputs for it. The monitor compares the outputs one nanosecond later, before the next rising edge, so every check sees the flags as they stood after the previous edge.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  parameter int unsigned CAUSE_W    = 32;
  parameter int unsigned CAUSE_CODE = 16;
endpackage

// File: rtl/irq_busy_flag.sv
// Set/clear flag; set wins when both arrive together.
module irq_busy_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic busy_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    busy_o <= 1'b0;
    else if (set_i) busy_o <= 1'b1;
    else if (clr_i) busy_o <= 1'b0;
  end
endmodule

// File: rtl/irq_decide.sv
module irq_decide (
  input  logic rst_ni,
  input  logic trap_i,
  input  logic req_i,
  input  logic mret_i,
  input  logic gie_i,
  input  logic exc_busy_i,
  input  logic irq_busy_i,
  output logic grant_o,
  output logic ret_o,
  output logic exc_clr_o
);
  logic idle;
  assign idle      = !exc_busy_i && !irq_busy_i;
  assign grant_o   = rst_ni && req_i && gie_i && !trap_i && idle;
  // innermost handler unwinds first
  assign ret_o     = rst_ni && mret_i && irq_busy_i && !exc_busy_i;
  assign exc_clr_o = mret_i && exc_busy_i;
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned CW   = CAUSE_W,
  parameter int unsigned CODE = CAUSE_CODE
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          trap_i,
  input  logic          req_i,
  input  logic          mret_i,
  input  logic          gie_i,
  output logic          grant_o,
  output logic          ret_o,
  output logic [CW-1:0] cause_o
);
  localparam logic [CW-1:0] CauseVal = {1'b1, (CW-1)'(CODE)};

  logic exc_busy, irq_busy, exc_clr;

  irq_decide u_decide (
    .rst_ni    (rst_ni),
    .trap_i    (trap_i),
    .req_i     (req_i),
    .mret_i    (mret_i),
    .gie_i     (gie_i),
    .exc_busy_i(exc_busy),
    .irq_busy_i(irq_busy),
    .grant_o   (grant_o),
    .ret_o     (ret_o),
    .exc_clr_o (exc_clr)
  );

  irq_busy_flag u_exc_flag (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (trap_i),
    .clr_i (exc_clr),
    .busy_o(exc_busy)
  );

  irq_busy_flag u_irq_flag (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (grant_o),
    .clr_i (ret_o),
    .busy_o(irq_busy)
  );

  assign cause_o = CauseVal;
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int unsigned CW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          trap_i,
  input logic          req_i,
  input logic          gie_i,
  input logic          grant_o,
  input logic          ret_o,
  input logic [CW-1:0] cause_o
);
  assert_no_grant_without_enable_R2: assert property (@(posedge clk_i)
    disable iff (!rst_ni) !gie_i |-> !grant_o);

  assert_no_back_to_back_grant_R3: assert property (@(posedge clk_i)
    disable iff (!rst_ni) grant_o |=> !grant_o);

  assert_trap_blocks_R4: assert property (@(posedge clk_i)
    disable iff (!rst_ni) trap_i |-> !grant_o);

  assert_trap_blocks_next_R4: assert property (@(posedge clk_i)
    disable iff (!rst_ni) trap_i |=> !grant_o);

  assert_grant_after_ret_R5: assert property (@(posedge clk_i)
    disable iff (!rst_ni) (ret_o && !trap_i) |=> ((req_i && gie_i && !trap_i) -> grant_o));

  assert_ret_not_with_grant_R3: assert property (@(posedge clk_i)
    disable iff (!rst_ni) ret_o |-> !grant_o);

  assert_quiet_in_reset_R9: assert property (@(posedge clk_i)
    !rst_ni |-> (!grant_o && !ret_o));

  always_comb begin
    assert_cause_const_R8: assert (cause_o == {1'b1, (CW-1)'(16)});
  end
endmodule

bind irq_ctrl irq_ctrl_chk #(.CW(CW)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .trap_i (trap_i),
  .req_i  (req_i),
  .gie_i  (gie_i),
  .grant_o(grant_o),
  .ret_o  (ret_o),
  .cause_o(cause_o)
);

// File: tb/irq_ctrl_tb.sv
`timescale 1ns/1ps
module irq_ctrl_tb;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic trap_i = 1'b0, req_i = 1'b0, mret_i = 1'b0, gie_i = 1'b0;
  logic grant_o, ret_o;
  logic [31:0] cause_o;

  typedef struct {
    logic  g;
    logic  r;
    string tag;
  } exp_t;
  exp_t q[$];
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;  // 250 MHz

  irq_ctrl u_dut (.*);

  // driver: apply a vector at the falling edge, queue what it must produce
  task automatic step(input logic rst, input logic tr, input logic rq,
                      input logic mr, input logic ge,
                      input logic eg, input logic er, input string tag);
    exp_t e;
    @(negedge clk_i);
    rst_ni = rst; trap_i = tr; req_i = rq; mret_i = mr; gie_i = ge;
    e.g = eg; e.r = er; e.tag = tag;
    q.push_back(e);
  endtask

  // drive with no check
  task automatic drive(input logic tr, input logic rq, input logic mr, input logic ge);
    @(negedge clk_i);
    rst_ni = 1'b1; trap_i = tr; req_i = rq; mret_i = mr; gie_i = ge;
  endtask

  task automatic do_reset();
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R9 reset with request");
    step(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R9 reset with mret");
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk_i);
      #1;
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (grant_o !== e.g || ret_o !== e.r) begin
          fails++;
          $display("FAIL %s: grant=%b ret=%b expected grant=%b ret=%b",
                   e.tag, grant_o, ret_o, e.g, e.r);
        end
        checks++;
        if (cause_o !== 32'h8000_0010) begin
          fails++;
          $display("FAIL R8 %s: cause=%h expected 80000010", e.tag, cause_o);
        end
      end
    end
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: done=0 expected 1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R1 granted request
    do_reset();
    step(1, 0, 1, 0, 1, 1, 0, "R1 grant when idle");
    // R2 enable low
    do_reset();
    step(1, 0, 1, 0, 0, 0, 0, "R2 enable low");
    step(1, 1, 1, 0, 0, 0, 0, "R2 enable low with trap");
    // R3 second request while handling
    do_reset();
    drive(0, 1, 0, 1);
    step(1, 0, 0, 0, 1, 0, 0, "R3 idle after grant");
    step(1, 0, 1, 0, 1, 0, 0, "R3 request while handling");
    // R4 request after exception
    do_reset();
    drive(1, 0, 0, 1);
    step(1, 0, 1, 0, 1, 0, 0, "R4 request cycle after trap");
    step(1, 1, 0, 0, 1, 0, 0, "R4 trap again");
    // R4 same cycle
    do_reset();
    step(1, 1, 1, 0, 1, 0, 0, "R4 request with trap");
    step(1, 0, 1, 0, 1, 0, 0, "R4 request after trap-with-request");
    // R5 return from interrupt only
    do_reset();
    drive(0, 1, 0, 1);
    step(1, 0, 0, 1, 1, 0, 1, "R5 return from interrupt");
    step(1, 0, 1, 0, 1, 1, 0, "R5 request after return");
    // R6 return from exception only
    do_reset();
    drive(1, 0, 0, 1);
    step(1, 0, 0, 1, 1, 0, 0, "R6 return from exception");
    step(1, 0, 1, 0, 1, 1, 0, "R6 request after return");
    // R7 nested, one return then request
    do_reset();
    drive(0, 1, 0, 1);
    step(1, 1, 0, 0, 1, 0, 0, "R7 trap inside interrupt");
    step(1, 0, 0, 1, 1, 0, 0, "R7 first return");
    step(1, 0, 1, 0, 1, 0, 0, "R7 request after first return");
    // R7 nested, two returns then request
    do_reset();
    drive(0, 1, 0, 1);
    drive(1, 0, 0, 1);
    step(1, 0, 0, 1, 1, 0, 0, "R7 first return");
    step(1, 0, 0, 0, 1, 0, 0, "R7 gap");
    step(1, 0, 0, 1, 1, 0, 1, "R7 second return");
    step(1, 0, 1, 0, 1, 1, 0, "R7 request after second return");
    // R9 reset mid-handler clears flags
    do_reset();
    drive(0, 1, 0, 1);
    do_reset();
    step(1, 0, 0, 1, 1, 0, 0, "R9 return after reset");
    step(1, 0, 1, 0, 1, 1, 0, "R9 grant after reset");
    @(negedge clk_i);
    @(negedge clk_i);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule